// File: doc/BRIEF.md
# Flow-through word memory with modified-range dump

A word-addressed storage block with 16-bit words and a 16-bit address. Each cycle, two control inputs, `enable` and `wr`, select one of three operations: idle, read or write. A read is combinational. The word at the current address appears on `data_out` within the same cycle and follows any change of address without waiting for a clock edge. A write is committed at the rising clock edge. In every cycle that is not a read, `data_out` is held at zero. The number of words is a power-of-two parameter. The full size is 65536 words, and smaller sizes suit simulation. When the depth is below 65536, the address is taken modulo the depth.

The block also records the highest address that a write cycle has touched since reset. When a dump request is sampled at a clock edge, the block streams the modified range on a dedicated output port, one word per cycle, starting at address zero and ending at that highest address. A single-cycle completion pulse follows the last word. This lets a bench or a debug path capture everything a program has changed without scanning the whole array. A synchronous reset clears every word, clears the tracker and abandons any dump in progress.

Top module: `flow_mem`

## Requirements
- R1: With `enable`=1 and `wr`=0, `data_out` equals the stored word at `addr`, combinationally, and it follows a change of `addr` inside the same cycle.
- R2: With `enable`=0, `data_out` is 0 whatever the value of `wr`, and no word is changed.
- R3: With `enable`=1 and `wr`=1, `data_in` is stored at `addr` on the rising edge, and `data_out` is 0 during that cycle.
- R4: Reset (`rst`=1 at a rising edge) makes every word read as 0, clears the highest-written record, and stops any dump. `dump_valid` and `dump_done` are 0 after reset, and no completion pulse follows an aborted dump.
- R5: A `dump_req` that is sampled at edge T while no dump is running starts a dump. At edge T+1+k the block sets `dump_valid`=1, `dump_addr`=k and `dump_data`=word k, for k = 0 to H. `dump_done` is high for exactly one cycle, set at the edge after the one that presents the last word, and `dump_valid` is 0 in that cycle.
- R6: H is the highest address (modulo the depth) written by a cycle with `enable`=1 and `wr`=1 since reset. Idle cycles and reads never change it.
- R7: If no write has occurred since reset, a dump request sets only `dump_done`, for one cycle, at edge T+1, and `dump_valid` stays 0.
- R8: A write during a dump updates the array and H. A word that is streamed after the write's edge shows the new value. The stopping address of the running dump stays the H captured at edge T.
- R9: A `dump_req` that is sampled while a dump is running is ignored. No second dump follows.
- R10: With a depth D below 65536, address A selects word A mod D for reads, writes and the H record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Selects an access this cycle |
| wr | input | 1 | 1 selects a write, 0 selects a read (when enabled) |
| addr | input | 16 | Word address |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Combinational read data, 0 unless reading |
| dump_req | input | 1 | Dump request, sampled at the clock edge |
| dump_valid | output | 1 | A dump word is present on dump_addr/dump_data |
| dump_addr | output | 16 | Address of the streamed word |
| dump_data | output | 16 | Content of the streamed word |
| dump_done | output | 1 | One-cycle pulse ending a dump |

## Verification
The bench targets the corner cases where simple mistakes show up. The first is a disabled cycle with `wr` high: a design that ignores `enable` would overwrite a word and output stale data. The second is an address above the depth, where a design with a faulty fold would alias to the wrong word or skip the record of the highest address. For the dump, the bench checks four cases: an empty dump, which should give a lone completion pulse; a write that lands ahead of the stream pointer, which must show up in the stream; a write above the captured stop point, which must not extend the running stream; and a repeated request, which must not restart the stream. The bench also aborts a dump with reset and expects a silent port and an empty tracker afterwards. A design that leaves stale valid bits would read nonzero words there, or emit a late completion pulse.

// File: rtl/flow_mem_pkg.sv
package flow_mem_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic {
    DS_IDLE = 1'b0,
    DS_RUN  = 1'b1
  } dump_state_t;
endpackage

// File: rtl/fm_store.sv
module fm_store
  import flow_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  word_t         wdata,
  input  logic [IW-1:0] ridx_a,
  output word_t         rdata_a,
  input  logic [IW-1:0] ridx_b,
  output word_t         rdata_b
);
  // Array without reset so it maps to RAM; a flop-based written flag per
  // word gives the one-cycle clear that reset needs.
  word_t            mem [DEPTH];
  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[widx] <= 1'b1;
  end

  assign rdata_a = written[ridx_a] ? mem[ridx_a] : '0;
  assign rdata_b = written[ridx_b] ? mem[ridx_b] : '0;

  // R4: after reset nothing reads back nonzero on either port
  p_cleared_r4: assert property (@(posedge clk) rst |=> (rdata_a == '0 && rdata_b == '0));
  // R3: a committed write is visible on the read port at the same index
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (we && ridx_a == widx) |=> (ridx_a != $past(widx) || rdata_a == $past(wdata)));
endmodule

// File: rtl/fm_hwm.sv
module fm_hwm #(
  parameter int unsigned IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  output logic [IW-1:0] hwm,
  output logic          hwm_any
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hwm     <= '0;
      hwm_any <= 1'b0;
    end else if (we && (!hwm_any || widx > hwm)) begin
      hwm     <= widx;
      hwm_any <= 1'b1;
    end
  end

  // R6: a write leaves the record at or above its index
  p_covers_write_r6: assert property (@(posedge clk) disable iff (rst)
    we |=> (hwm_any && hwm >= $past(widx)));
  // R6: the record never moves down without reset
  p_monotone_r6: assert property (@(posedge clk) disable iff (rst)
    hwm_any |=> (hwm_any && hwm >= $past(hwm)));
  // R6: no write, no change
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(hwm) && $stable(hwm_any)));
endmodule

// File: rtl/fm_dump.sv
module fm_dump
  import flow_mem_pkg::*;
#(
  parameter int unsigned IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [IW-1:0] hwm,
  input  logic          hwm_any,
  output logic [IW-1:0] rd_idx,
  input  word_t         rd_data,
  output logic          dump_valid,
  output addr_t         dump_addr,
  output word_t         dump_data,
  output logic          dump_done
);
  dump_state_t   st;
  logic [IW-1:0] ptr;
  logic [IW-1:0] last;
  logic          tail;

  assign rd_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= DS_IDLE;
      ptr        <= '0;
      last       <= '0;
      tail       <= 1'b0;
      dump_valid <= 1'b0;
      dump_addr  <= '0;
      dump_data  <= '0;
      dump_done  <= 1'b0;
    end else begin
      dump_done  <= tail;
      tail       <= 1'b0;
      dump_valid <= 1'b0;
      unique case (st)
        DS_IDLE: begin
          if (req) begin
            if (hwm_any) begin
              st   <= DS_RUN;
              ptr  <= '0;
              last <= hwm;
            end else begin
              tail <= 1'b1;
            end
          end
        end
        DS_RUN: begin
          dump_valid <= 1'b1;
          dump_addr  <= addr_t'(ptr);
          dump_data  <= rd_data;
          if (ptr == last) begin
            st   <= DS_IDLE;
            tail <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

  // R4: reset silences the dump port
  p_reset_quiet_r4: assert property (@(posedge clk) rst |=> (!dump_valid && !dump_done));
  // R5: a stream starts at address zero
  p_first_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dump_valid) |-> dump_addr == '0);
  // R5: consecutive words step by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (dump_valid && $past(dump_valid)) |-> dump_addr == $past(dump_addr) + 1'b1);
  // R5: completion is a single pulse and never overlaps a word
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> (!dump_valid && !$past(dump_done)));
  // R8: the stop point is frozen while streaming
  p_stop_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    (st == DS_RUN && $past(st == DS_RUN)) |-> ($stable(last) && ptr <= last));
endmodule

// File: rtl/flow_mem.sv
module flow_mem
  import flow_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  logic  wr,
  input  addr_t addr,
  input  word_t data_in,
  output word_t data_out,
  input  logic  dump_req,
  output logic  dump_valid,
  output addr_t dump_addr,
  output word_t dump_data,
  output logic  dump_done
);
  logic [IW-1:0] idx;
  logic          we;
  word_t         rd_a;
  logic [IW-1:0] dump_idx;
  word_t         rd_b;
  logic [IW-1:0] hwm;
  logic          hwm_any;

  // R10: fold the address onto the configured depth
  assign idx = addr[IW-1:0];
  generate
    if (IW < ADDR_W) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:IW];
    end
  endgenerate

  assign we       = enable && wr && !rst;
  assign data_out = (enable && !wr) ? rd_a : '0;

  fm_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .widx   (idx),
    .wdata  (data_in),
    .ridx_a (idx),
    .rdata_a(rd_a),
    .ridx_b (dump_idx),
    .rdata_b(rd_b)
  );

  fm_hwm #(.IW(IW)) u_hwm (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .widx   (idx),
    .hwm    (hwm),
    .hwm_any(hwm_any)
  );

  fm_dump #(.IW(IW)) u_dump (
    .clk       (clk),
    .rst       (rst),
    .req       (dump_req),
    .hwm       (hwm),
    .hwm_any   (hwm_any),
    .rd_idx    (dump_idx),
    .rd_data   (rd_b),
    .dump_valid(dump_valid),
    .dump_addr (dump_addr),
    .dump_data (dump_data),
    .dump_done (dump_done)
  );

  // R2: idle cycles drive zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |-> data_out == '0);
  // R3: write cycles drive zero
  p_write_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (enable && wr) |-> data_out == '0);
endmodule

// File: tb/tb_flow_mem.sv
module tb_flow_mem;
  localparam int unsigned DEPTH_B = 1024;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        dump_req = 1'b0;
  logic        dump_valid;
  logic [15:0] dump_addr;
  logic [15:0] dump_data;
  logic        dump_done;

  always #2 clk = ~clk;

  flow_mem #(.DEPTH(DEPTH_B)) dut (
    .clk(clk), .rst(rst), .enable(enable), .wr(wr), .addr(addr),
    .data_in(data_in), .data_out(data_out), .dump_req(dump_req),
    .dump_valid(dump_valid), .dump_addr(dump_addr), .dump_data(dump_data),
    .dump_done(dump_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_mem [DEPTH_B];
  int hwm_b = -1;

  // {enable, wr, addr, data_in, expected data_out}
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'd5,    16'h1111, 16'h0000},
    {1'b1, 1'b1, 16'd10,   16'h2222, 16'h0000},
    {1'b1, 1'b0, 16'd5,    16'h0000, 16'h1111},
    {1'b1, 1'b0, 16'd10,   16'h0000, 16'h2222},
    {1'b1, 1'b0, 16'd7,    16'h0000, 16'h0000},
    {1'b0, 1'b1, 16'd5,    16'h9999, 16'h0000},
    {1'b1, 1'b0, 16'd5,    16'h0000, 16'h1111},
    {1'b1, 1'b1, 16'd1029, 16'h3333, 16'h0000},
    {1'b1, 1'b0, 16'd5,    16'h0000, 16'h3333},
    {1'b1, 1'b0, 16'd1029, 16'h0000, 16'h3333},
    {1'b1, 1'b1, 16'd3,    16'hABCD, 16'h0000},
    {1'b1, 1'b0, 16'd3,    16'h0000, 16'hABCD},
    {1'b0, 1'b0, 16'd3,    16'h0000, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [15:0] d);
    int i;
    i = int'(a) % DEPTH_B;
    exp_mem[i] = d;
    if (i > hwm_b) hwm_b = i;
  endtask

  // Watches the dump port until the completion pulse.
  task automatic collect(input int n, input string tag);
    int  words = 0;
    bit  prev  = 1'b0;
    bit  done  = 1'b0;
    for (int c = 0; c < DEPTH_B + 8 && !done; c++) begin
      @(negedge clk); #1;
      if (dump_valid) begin
        chk(dump_addr == 16'(words), tag, "dump_addr", dump_addr, words);
        chk(dump_data == exp_mem[words % DEPTH_B], tag, "dump_data",
            dump_data, exp_mem[words % DEPTH_B]);
        words++;
      end
      if (dump_done) begin
        done = 1'b1;
        chk(words == n, tag, "word count", words, n);
        chk(n == 0 || prev, tag, "done right after last word", prev, 1);
        chk(!dump_valid, tag, "valid low at done", dump_valid, 0);
      end
      prev = dump_valid;
    end
    chk(done, tag, "completion seen", done, 1);
    // R9: no restarted stream afterwards
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(!dump_valid && !dump_done, "R9", "port quiet after dump",
          {dump_valid, dump_done}, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH_B; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4: reset state
    enable = 1'b1; wr = 1'b0; addr = 16'd5; #1;
    chk(data_out == 16'h0, "R4", "cleared word", data_out, 0);
    chk(!dump_valid && !dump_done, "R4", "dump port idle", {dump_valid, dump_done}, 0);
    enable = 1'b0;

    // R7: dump with nothing written
    @(negedge clk); dump_req = 1'b1;
    fork
      collect(0, "R7");
      begin @(negedge clk); dump_req = 1'b0; end
    join

    // R1 R2 R3 R10: vector walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      @(negedge clk);
      {enable, wr, addr, data_in} = VEC[v][49:16];
      #1;
      if (!VEC[v][49])     tag = "R2";
      else if (VEC[v][48]) tag = "R3";
      else if (VEC[v][47:16] >= 32'(DEPTH_B) << 16) tag = "R10";
      else                 tag = "R1";
      chk(data_out == VEC[v][15:0], tag, "data_out", data_out, VEC[v][15:0]);
      if (VEC[v][49] && VEC[v][48]) model_write(VEC[v][47:32], VEC[v][31:16]);
    end

    // R1: flow-through inside one cycle
    @(negedge clk);
    enable = 1'b1; wr = 1'b0; addr = 16'd3; #1;
    chk(data_out == 16'hABCD, "R1", "flow read a", data_out, 16'hABCD);
    addr = 16'd10; #1;
    chk(data_out == 16'h2222, "R1", "flow read b", data_out, 16'h2222);
    enable = 1'b0;

    // R5 R6: full dump of 0..10
    chk(hwm_b == 10, "R6", "bench tracker", hwm_b, 10);
    @(negedge clk); dump_req = 1'b1;
    fork
      collect(hwm_b + 1, "R5");
      begin @(negedge clk); dump_req = 1'b0; end
    join

    // R8 R9: writes and a repeat request while streaming
    @(negedge clk); dump_req = 1'b1;
    fork
      collect(11, "R8");
      begin
        @(negedge clk);
        dump_req = 1'b0; enable = 1'b1; wr = 1'b1; addr = 16'd8; data_in = 16'h8888;
        model_write(16'd8, 16'h8888);
        @(negedge clk);
        addr = 16'd20; data_in = 16'h2020; dump_req = 1'b1;
        model_write(16'd20, 16'h2020);
        @(negedge clk);
        enable = 1'b0; wr = 1'b0; dump_req = 1'b0;
      end
    join

    // R6 R8: next dump reaches the raised record
    @(negedge clk); dump_req = 1'b1;
    fork
      collect(21, "R6");
      begin @(negedge clk); dump_req = 1'b0; end
    join

    // R4: reset aborts a running dump
    @(negedge clk); dump_req = 1'b1;
    @(negedge clk); dump_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!dump_valid && !dump_done, "R4", "abort quiet", {dump_valid, dump_done}, 0);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk(!dump_valid && !dump_done, "R4", "no late stream", {dump_valid, dump_done}, 0);
    end
    for (int i = 0; i < DEPTH_B; i++) exp_mem[i] = '0;
    hwm_b = -1;
    enable = 1'b1; wr = 1'b0; addr = 16'd20; #1;
    chk(data_out == 16'h0, "R4", "word cleared", data_out, 0);
    enable = 1'b0;
    @(negedge clk); dump_req = 1'b1;
    fork
      collect(0, "R4");
      begin @(negedge clk); dump_req = 1'b0; end
    join

    summary();
  end
endmodule